// File: doc/BRIEF.md
# Polled Byte Serial Port with Receive Hold-Off

This block gives an 8-bit CPU a serial console through two adjacent I/O addresses: a status/control location and a data location. The serial side is byte-parallel. Incoming bytes arrive on a valid/ready stream and outgoing bytes leave on another valid/ready stream. No baud-rate generation, framing or parity logic is included.

The receive source is not examined on every clock. A free-running tick counter opens a one-cycle sampling window each time its low bits wrap to zero, which is once per 256 ticks by default. In that window a waiting byte is taken into a one-byte holding register and a receive-full flag is raised. Software can hold the source off through an RTS field in the control register. It can also enable an active-low interrupt that stays low while a received byte is waiting.

The CPU bus uses a select strobe with a write enable. Read data is registered and appears on the cycle after the access.

Top module: `polled_serial_port`

## Requirements
- R1: After reset the read data output is 0x00, `irq_n` is 1, `tx_valid` is 0, the control register is zero (interrupt disabled, RTS field 00), and a status read returns 0x02 while `tx_ready` is 1.
- R2: The tick counter is 0 in the first cycle after reset is released and increments every cycle. A byte is taken from the source (`rx_ready` high for that one cycle) only in a cycle where the counter's low SAMPLE_BITS bits are all zero.
- R3: In a sampling cycle where `rx_valid` is 1, the receive-full flag is clear, the RTS field does not hold off, and no master reset is written, the byte on `rx_data` is captured and status bit 0 (receive full) becomes 1. While the flag is set, no further byte is taken and the captured byte is not overwritten.
- R4: While control bits 6:5 equal 2'b10 (RTS deasserted), no byte is taken from the source. The other three codes allow reception.
- R5: A read at STAT_ADDR (0x80) returns, on the next cycle, bit 0 = receive full, bit 1 = transmit empty (`tx_ready` is 1 and no byte is pending), bit 7 = interrupt request (receive full and interrupt enabled), and all other bits 0. It changes no state.
- R6: A read at DATA_ADDR (0x81) returns the last captured byte on the next cycle and clears the receive-full flag.
- R7: `irq_n` goes low one cycle after both receive full and control bit 7 (receive-interrupt enable) are 1. It returns high one cycle after either becomes 0.
- R8: A write at DATA_ADDR with no byte pending makes `tx_valid` 1 with that byte on `tx_data` from the next cycle. The pair holds steady until `tx_ready` is 1. A write while a byte is pending is ignored.
- R9: A write at STAT_ADDR loads control bits 7 and 6:5. If write-data bits 1:0 are 2'b11 it also performs a master reset: it clears receive full, drops any pending transmit byte and releases the interrupt.
- R10: Accesses to any other address change no state and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | CPU I/O access strobe, one cycle per access |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W (8) | I/O address |
| io_wdata | input | DATA_W (8) | Write data |
| io_rdata | output | DATA_W (8) | Registered read data, valid the cycle after a read |
| rx_valid | input | 1 | Receive source has a byte |
| rx_data | input | DATA_W (8) | Receive source byte |
| rx_ready | output | 1 | Byte taken from the source this cycle |
| tx_valid | output | 1 | Transmit byte pending |
| tx_data | output | DATA_W (8) | Transmit byte |
| tx_ready | input | 1 | Transmit sink accepts a byte |
| irq_n | output | 1 | Active-low receive interrupt |

## Verification
The bench builds the block with its default values: an 8-bit sampling window (256 ticks) and ports 0x80/0x81. Bytes are therefore offered at arbitrary points of the window, and a single offer can wait out a full wrap of the counter. Hold-off is checked over more than two whole windows, so a byte leaked by the RTS gate or by a mis-sized counter would show up. A behavioural model, built from integers and a queue, predicts read data, `rx_ready`, `irq_n` and the transmit pair on every clock. Directed sequences then cover back-to-back offers against a full holding register, pending transmit bytes under backpressure, master reset while an interrupt is active, and stray addresses.

// File: rtl/psp_pkg.sv
package psp_pkg;
  // RTS field codes in control bits 6:5
  localparam logic [1:0] RTS_LOW      = 2'b00;
  localparam logic [1:0] RTS_LOW_TXI  = 2'b01;
  localparam logic [1:0] RTS_HIGH     = 2'b10;
  localparam logic [1:0] RTS_LOW_BRK  = 2'b11;
  // control write low bits that request a master reset
  localparam logic [1:0] MRESET_CODE  = 2'b11;
  // status bit positions
  localparam int ST_RXFULL = 0;
  localparam int ST_TXEMPTY = 1;
  localparam int ST_IRQ = 7;
  // control bit positions
  localparam int CT_RIE = 7;
  localparam int CT_RTS_LO = 5;
endpackage

// File: rtl/psp_tick_gate.sv
module psp_tick_gate #(
  parameter int SAMPLE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  output logic sample
);
  logic [SAMPLE_BITS-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) tick_cnt <= '0;
    else     tick_cnt <= tick_cnt + 1'b1;
  end

  assign sample = (tick_cnt == '0);
endmodule

// File: rtl/psp_ctrl_reg.sv
module psp_ctrl_reg
  import psp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              rie,
  output logic              rts_hold,
  output logic              mreset
);
  logic [1:0] rts_field;

  always_ff @(posedge clk) begin
    if (rst) begin
      rie       <= 1'b0;
      rts_field <= RTS_LOW;
    end else if (wr_en) begin
      rie       <= wdata[CT_RIE];
      rts_field <= wdata[CT_RTS_LO +: 2];
    end
  end

  assign rts_hold = (rts_field == RTS_HIGH);
  assign mreset   = wr_en && (wdata[1:0] == MRESET_CODE);
endmodule

// File: rtl/psp_rx_hold.sv
module psp_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              hold_off,
  input  logic              mreset,
  input  logic              rd_clr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_take,
  output logic              full,
  output logic [DATA_W-1:0] held
);
  assign src_take = sample && src_valid && !hold_off && !full && !mreset;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      held <= '0;
    end else begin
      if (src_take) held <= src_data;
      if (mreset)        full <= 1'b0;
      else if (src_take) full <= 1'b1;
      else if (rd_clr)   full <= 1'b0;
    end
  end

  // R2
  take_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    src_take |-> sample);
  // R3
  take_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    src_take |=> full);
  // R3
  held_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_clr && !mreset) |=> (full && $stable(held)));
endmodule

// File: rtl/psp_tx_hold.sv
module psp_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mreset,
  input  logic              sink_ready,
  output logic              pend,
  output logic [DATA_W-1:0] pend_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_data <= '0;
    end else if (mreset) begin
      pend <= 1'b0;
    end else if (wr_en && !pend) begin
      pend      <= 1'b1;
      pend_data <= wdata;
    end else if (pend && sink_ready) begin
      pend <= 1'b0;
    end
  end

  // R8
  tx_hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !sink_ready && !mreset) |=> (pend && $stable(pend_data)));
endmodule

// File: rtl/polled_serial_port.sv
module polled_serial_port
  import psp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SAMPLE_BITS = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h80,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h81
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_sel,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              irq_n
);
  logic hit_stat, hit_data;
  logic rd_stat, rd_data, wr_stat, wr_data;
  logic sample, rie, rts_hold, mreset;
  logic rx_full;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] status_word;

  assign hit_stat = io_sel && (io_addr == STAT_ADDR);
  assign hit_data = io_sel && (io_addr == DATA_ADDR);
  assign rd_stat  = hit_stat && !io_we;
  assign rd_data  = hit_data && !io_we;
  assign wr_stat  = hit_stat && io_we;
  assign wr_data  = hit_data && io_we;

  psp_tick_gate #(.SAMPLE_BITS(SAMPLE_BITS)) tick_i (
    .clk(clk), .rst(rst), .sample(sample));

  psp_ctrl_reg #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rst(rst), .wr_en(wr_stat), .wdata(io_wdata),
    .rie(rie), .rts_hold(rts_hold), .mreset(mreset));

  psp_rx_hold #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst(rst), .sample(sample), .hold_off(rts_hold),
    .mreset(mreset), .rd_clr(rd_data), .src_valid(rx_valid),
    .src_data(rx_data), .src_take(rx_ready), .full(rx_full), .held(rx_byte));

  psp_tx_hold #(.DATA_W(DATA_W)) tx_i (
    .clk(clk), .rst(rst), .wr_en(wr_data), .wdata(io_wdata),
    .mreset(mreset), .sink_ready(tx_ready), .pend(tx_valid), .pend_data(tx_data));

  always_comb begin
    status_word = '0;
    status_word[ST_RXFULL]  = rx_full;
    status_word[ST_TXEMPTY] = tx_ready && !tx_valid;
    status_word[ST_IRQ]     = rx_full && rie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
      irq_n    <= 1'b1;
    end else begin
      irq_n <= !(rx_full && rie);
      if (rd_stat)      io_rdata <= status_word;
      else if (rd_data) io_rdata <= rx_byte;
      else              io_rdata <= '0;
    end
  end

  // R4
  rts_blocks_take_chk: assert property (@(posedge clk) disable iff (rst)
    rts_hold |-> !rx_ready);
  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |=> irq_n);
  // R9
  mreset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    mreset |=> (!rx_full && !tx_valid));
endmodule

// File: tb/polled_serial_port_tb_top.sv
`timescale 1ns/1ps
module polled_serial_port_tb_top;
  localparam int SB = 8;
  localparam int WIN = 1 << SB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_sel = 1'b0, io_we = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic irq_n;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  polled_serial_port #(.SAMPLE_BITS(SB)) dut_i (
    .clk(clk), .rst(rst), .io_sel(io_sel), .io_we(io_we), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq_n(irq_n));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- receive source ----------------
  byte unsigned rxq[$];
  bit popflag = 0;
  initial forever begin
    @(negedge clk);
    if (rx_valid && rx_ready) popflag = 1;
  end
  initial forever begin
    @(posedge clk); #1;
    if (popflag) begin void'(rxq.pop_front()); popflag = 0; end
    rx_valid = (rxq.size() > 0);
    rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
  end

  // ---------------- reference model ----------------
  int  m_cnt;
  bit  m_full, m_rie, m_irqn, m_txv;
  bit [1:0] m_rts;
  byte unsigned m_byte, m_rdata, m_txd;
  bit  live = 0;

  function automatic bit m_mr();
    return io_sel && io_we && io_addr == 8'h80 && io_wdata[1:0] == 2'b11;
  endfunction
  function automatic bit m_take();
    return (m_cnt % WIN == 0) && rx_valid && m_rts != 2'b10 && !m_full && !m_mr();
  endfunction

  always @(posedge clk) begin
    bit rd, wr, mr, tk;
    if (rst) begin
      m_cnt <= 0; m_full <= 0; m_byte <= 0; m_rie <= 0; m_rts <= 0;
      m_rdata <= 0; m_irqn <= 1; m_txv <= 0; m_txd <= 0;
    end else begin
      rd = io_sel && !io_we; wr = io_sel && io_we;
      mr = m_mr(); tk = m_take();
      m_cnt <= (m_cnt + 1) % WIN;
      if (tk) m_byte <= rx_data;
      if (mr) m_full <= 0;
      else if (tk) m_full <= 1;
      else if (rd && io_addr == 8'h81) m_full <= 0;
      if (rd && io_addr == 8'h80)
        m_rdata <= {m_full && m_rie, 5'b0, tx_ready && !m_txv, m_full};
      else if (rd && io_addr == 8'h81) m_rdata <= m_byte;
      else m_rdata <= 0;
      if (wr && io_addr == 8'h80) begin m_rie <= io_wdata[7]; m_rts <= io_wdata[6:5]; end
      m_irqn <= !(m_full && m_rie);
      if (mr) m_txv <= 0;
      else if (wr && io_addr == 8'h81 && !m_txv) begin m_txv <= 1; m_txd <= io_wdata; end
      else if (m_txv && tx_ready) m_txv <= 0;
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      check(io_rdata == m_rdata, "R5/R6 io_rdata", io_rdata, m_rdata);
      check(irq_n == m_irqn, "R7 irq_n", irq_n, m_irqn);
      check(rx_ready == m_take(), "R2/R3/R4 rx_ready", rx_ready, m_take());
      check(tx_valid == m_txv, "R8 tx_valid", tx_valid, m_txv);
      if (m_txv) check(tx_data == m_txd, "R8 tx_data", tx_data, m_txd);
    end
  end

  // ---------------- CPU tasks ----------------
  task automatic cpu_wr(input byte unsigned a, input byte unsigned d);
    @(posedge clk); #1;
    io_sel = 1; io_we = 1; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    io_sel = 0; io_we = 0;
  endtask

  task automatic cpu_rd(input byte unsigned a, output byte unsigned d);
    @(posedge clk); #1;
    io_sel = 1; io_we = 0; io_addr = a;
    @(posedge clk); #1;
    io_sel = 0;
    d = io_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic wait_rxfull(output bit got);
    byte unsigned s;
    got = 0;
    for (int i = 0; i < 3 * WIN && !got; i++) begin
      cpu_rd(8'h80, s);
      got = s[0];
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    byte unsigned d;
    bit got;
    repeat (3) @(posedge clk);
    #1; rst = 0; live = 1;

    // R1 reset state
    check(io_rdata == 8'h00, "R1 rdata after reset", io_rdata, 0);
    check(irq_n == 1'b1, "R1 irq_n after reset", irq_n, 1);
    check(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
    cpu_rd(8'h80, d);
    check(d == 8'h02, "R1 R5 status after reset", d, 8'h02);

    // R2 R3 R6: single byte offered mid-window
    idle(37);
    rxq.push_back(8'h5A);
    wait_rxfull(got);
    check(got, "R3 receive full raised", got, 1);
    cpu_rd(8'h81, d);
    check(d == 8'h5A, "R6 data read", d, 8'h5A);
    cpu_rd(8'h80, d);
    check(d[0] == 1'b0, "R6 full cleared by data read", d[0], 0);

    // R3: two bytes, second waits while full
    rxq.push_back(8'h11); rxq.push_back(8'h22);
    wait_rxfull(got);
    idle(2 * WIN);
    check(rx_valid == 1'b1 && rx_data == 8'h22, "R3 second byte not taken while full", rx_data, 8'h22);
    cpu_rd(8'h81, d);
    check(d == 8'h11, "R3 first byte kept", d, 8'h11);
    wait_rxfull(got);
    cpu_rd(8'h81, d);
    check(d == 8'h22, "R3 second byte after drain", d, 8'h22);

    // R4: RTS high blocks reception
    cpu_wr(8'h80, 8'h40);
    rxq.push_back(8'h99);
    idle(2 * WIN + 20);
    cpu_rd(8'h80, d);
    check(d[0] == 1'b0, "R4 no receive while RTS high", d[0], 0);
    check(rx_valid == 1'b1, "R4 source byte still waiting", rx_valid, 1);
    cpu_wr(8'h80, 8'h20);
    wait_rxfull(got);
    check(got, "R4 receive resumes with RTS code 01", got, 1);
    cpu_rd(8'h81, d);
    check(d == 8'h99, "R4 held-off byte delivered", d, 8'h99);

    // R7: interrupt
    cpu_wr(8'h80, 8'h80);
    rxq.push_back(8'hC3);
    wait_rxfull(got);
    idle(1);
    check(irq_n == 1'b0, "R7 irq_n low with enable and full", irq_n, 0);
    cpu_rd(8'h80, d);
    check(d == 8'h83, "R5 status with irq pending", d, 8'h83);
    cpu_rd(8'h81, d);
    idle(1);
    check(irq_n == 1'b1, "R7 irq_n released after data read", irq_n, 1);

    // R8: transmit
    cpu_wr(8'h81, 8'hA5);
    idle(2);
    check(tx_valid == 1'b0, "R8 byte drained with ready", tx_valid, 0);
    tx_ready = 0;
    cpu_wr(8'h81, 8'h3C);
    check(tx_valid && tx_data == 8'h3C, "R8 pending byte", tx_data, 8'h3C);
    cpu_wr(8'h81, 8'h77);
    check(tx_data == 8'h3C, "R8 write while pending ignored", tx_data, 8'h3C);
    cpu_rd(8'h80, d);
    check(d[1] == 1'b0, "R5 tx not empty while pending", d[1], 0);
    idle(5);
    tx_ready = 1;
    idle(2);
    check(tx_valid == 1'b0, "R8 pending byte leaves on ready", tx_valid, 0);

    // R9: master reset with interrupt active and tx pending
    rxq.push_back(8'h6E);
    wait_rxfull(got);
    idle(1);
    tx_ready = 0;
    cpu_wr(8'h81, 8'h44);
    check(irq_n == 1'b0, "R9 precondition irq active", irq_n, 0);
    cpu_wr(8'h80, 8'h03);
    check(tx_valid == 1'b0, "R9 master reset drops tx", tx_valid, 0);
    idle(1);
    check(irq_n == 1'b1, "R9 master reset releases irq", irq_n, 1);
    tx_ready = 1;
    cpu_rd(8'h80, d);
    check(d == 8'h02, "R9 status after master reset", d, 8'h02);

    // R10: stray addresses
    cpu_wr(8'h80, 8'h80);
    cpu_wr(8'h82, 8'h43);
    cpu_wr(8'h7F, 8'h55);
    check(tx_valid == 1'b0, "R10 stray write no transmit", tx_valid, 0);
    cpu_rd(8'h82, d);
    check(d == 8'h00, "R10 stray read returns zero", d, 0);
    rxq.push_back(8'h3A);
    wait_rxfull(got);
    idle(1);
    check(irq_n == 1'b0, "R10 control kept after stray write", irq_n, 0);
    cpu_rd(8'h81, d);
    check(d == 8'h3A, "R6 last byte", d, 8'h3A);

    idle(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule